// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide parallel flash and turns single write cycles into memory operations. Each write is compared with the unlock-protected command sequences used by standard parallel flash parts. A byte program, a sector erase or a whole-array erase is only issued once its full sequence has arrived without error. The block also tracks a product-identification mode. In that mode, reads at the two lowest addresses return a manufacturer code and a device code in place of array contents.

Writes arrive as one-cycle `wr_valid` pulses. There is no back-pressure: every cycle with `wr_valid` high is either consumed or, while `busy` is high, thrown away. The array controller raises `busy` in the cycle after it sees a strobe and holds it until the operation completes. Any write that does not fit the sequence in progress sends the decoder back to plain read mode. That write is not reused as the start of a new sequence.

Top module: `jfc_cmd_decoder`

## Requirements
- R1: While reset is active, and in the first cycle after it, all three strobes are low and `id_mode` is low.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then any address and data, raise `prog_stb` for one cycle in the cycle after that last write. `prog_addr` and `prog_data` carry the last write's full address and data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address, raise `sec_erase_stb` in the cycle after the last write. `sec_addr` equals address bits ADDR_W-1 down to SECTOR_LSB (12 by default, giving 4 KB sectors).
- R4: The same five-write prefix followed by 10h at 5555h raises `chip_erase_stb` in the next cycle. 10h at any other command address aborts instead.
- R5: Command steps compare only address bits 14..0. Bits above 14 have no effect on recognition.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode` from the next cycle.
- R7: `id_hit` is high only when `id_mode` is high and `rd_addr` has every bit above bit 0 clear. `id_data` is then BFh for `rd_addr` = 0 and DEV_ID (B7h by default) for `rd_addr` = 1. Otherwise `id_data` is 00h.
- R8: Two sequences clear `id_mode` from the next cycle: a single F0h write at any address arriving while no sequence is in progress, and the three-write sequence ending in F0h@5555h.
- R9: A write that is not the expected next step returns the decoder to read mode, clears `id_mode` and issues no strobe. The offending write is discarded, even when it is AAh@5555h.
- R10: A write with `busy` high is ignored. It changes no strobe, does not touch `id_mode`, and leaves the position within a sequence unchanged. This includes F0h.
- R11: At most one strobe is high in any cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Internal program or erase running |
| rd_addr | input | ADDR_W | Read address for identification data |
| prog_stb | output | 1 | Byte program request, one cycle |
| prog_addr | output | ADDR_W | Byte address for the program request |
| prog_data | output | 8 | Byte value for the program request |
| sec_erase_stb | output | 1 | Sector erase request, one cycle |
| sec_addr | output | ADDR_W-SECTOR_LSB | Sector index for the erase request |
| chip_erase_stb | output | 1 | Whole-array erase request, one cycle |
| id_mode | output | 1 | Identification read mode active |
| id_hit | output | 1 | Current read is served from identification data |
| id_data | output | 8 | Identification byte for `rd_addr` |

## Verification
A sequence pointer stuck or advanced wrongly shows up at the ports at the end of the next command. The strobe appears one write too early or too late, is missing after a legal sequence, or fires after a broken one. An abort that is reused instead of discarded shows as an extra strobe when the bench follows a broken prefix with the rest of a command. A busy gate that leaks shows in the cycle after the ignored write, as a flipped `id_mode` or a strobe. The reference model checks every strobe, address, data and identification output on every clock, so each of these errors surfaces within one cycle of the write that exposes it.

// File: rtl/jfc_pkg.sv
package jfc_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] ADR_UNLOCK_A = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_ID_IN   = 8'h90;
  localparam logic [7:0] CODE_ID_OUT  = 8'hF0;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_WHOLE   = 8'h10;

  typedef enum logic [2:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ERA1,
    ST_ERA2,
    ST_ERA3
  } seq_e;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_key_a;
    logic d_key_b;
    logic d_prog;
    logic d_erase;
    logic d_id_in;
    logic d_id_out;
    logic d_sector;
    logic d_whole;
  } cyc_t;

endpackage

// File: rtl/jfc_cycle_class.sv
module jfc_cycle_class
  import jfc_pkg::*;
(
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output cyc_t              cls
);

  always_comb begin
    cls.at_a     = (cmd_addr == ADR_UNLOCK_A);
    cls.at_b     = (cmd_addr == ADR_UNLOCK_B);
    cls.d_key_a  = (cmd_data == CODE_KEY_A);
    cls.d_key_b  = (cmd_data == CODE_KEY_B);
    cls.d_prog   = (cmd_data == CODE_PROG);
    cls.d_erase  = (cmd_data == CODE_ERASE);
    cls.d_id_in  = (cmd_data == CODE_ID_IN);
    cls.d_id_out = (cmd_data == CODE_ID_OUT);
    cls.d_sector = (cmd_data == CODE_SECTOR);
    cls.d_whole  = (cmd_data == CODE_WHOLE);
  end

endmodule

// File: rtl/jfc_seq_fsm.sv
module jfc_seq_fsm
  import jfc_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECTOR_LSB = 12,
  localparam int SEC_W     = ADDR_W - SECTOR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  cyc_t              cls,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              sec_stb,
  output logic [SEC_W-1:0]  sec_addr,
  output logic              chip_stb,
  output logic              id_mode
);

  seq_e st_q, st_d;
  logic id_d;
  logic fire_prog, fire_sec, fire_chip;

  always_comb begin
    st_d      = st_q;
    id_d      = id_mode;
    fire_prog = 1'b0;
    fire_sec  = 1'b0;
    fire_chip = 1'b0;
    if (take) begin
      // default for every step below: mismatch drops to read mode
      st_d = ST_READ;
      id_d = 1'b0;
      unique case (st_q)
        ST_READ: begin
          if (cls.at_a && cls.d_key_a) begin
            st_d = ST_KEY1;
            id_d = id_mode;
          end
        end
        ST_KEY1: begin
          if (cls.at_b && cls.d_key_b) begin
            st_d = ST_KEY2;
            id_d = id_mode;
          end
        end
        ST_KEY2: begin
          if (cls.at_a) begin
            if (cls.d_prog) begin
              st_d = ST_PROG;
              id_d = id_mode;
            end else if (cls.d_erase) begin
              st_d = ST_ERA1;
              id_d = id_mode;
            end else if (cls.d_id_in) begin
              id_d = 1'b1;
            end
          end
        end
        ST_PROG: begin
          fire_prog = 1'b1;
          id_d      = id_mode;
        end
        ST_ERA1: begin
          if (cls.at_a && cls.d_key_a) begin
            st_d = ST_ERA2;
            id_d = id_mode;
          end
        end
        ST_ERA2: begin
          if (cls.at_b && cls.d_key_b) begin
            st_d = ST_ERA3;
            id_d = id_mode;
          end
        end
        ST_ERA3: begin
          if (cls.d_sector) begin
            fire_sec = 1'b1;
            id_d     = id_mode;
          end else if (cls.d_whole && cls.at_a) begin
            fire_chip = 1'b1;
            id_d      = id_mode;
          end
        end
        default: st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_READ;
      id_mode   <= 1'b0;
      prog_stb  <= 1'b0;
      sec_stb   <= 1'b0;
      chip_stb  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      sec_addr  <= '0;
    end else begin
      st_q     <= st_d;
      id_mode  <= id_d;
      prog_stb <= fire_prog;
      sec_stb  <= fire_sec;
      chip_stb <= fire_chip;
      if (fire_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (fire_sec) begin
        sec_addr <= wr_addr[ADDR_W-1:SECTOR_LSB];
      end
    end
  end

endmodule

// File: rtl/jfc_id_read.sv
module jfc_id_read #(
  parameter int          ADDR_W = 19,
  parameter logic [7:0]  MFR_ID = 8'hBF,
  parameter logic [7:0]  DEV_ID = 8'hB7
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_hit,
  output logic [7:0]        id_data
);

  logic upper_clear;

  always_comb begin
    upper_clear = (rd_addr[ADDR_W-1:1] == '0);
    id_hit      = id_mode && upper_clear;
    if (!id_hit)         id_data = 8'h00;
    else if (rd_addr[0]) id_data = DEV_ID;
    else                 id_data = MFR_ID;
  end

endmodule

// File: rtl/jfc_cmd_decoder.sv
module jfc_cmd_decoder
  import jfc_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         SECTOR_LSB = 12,
  parameter logic [7:0] MFR_ID     = 8'hBF,
  parameter logic [7:0] DEV_ID     = 8'hB7,
  localparam int        SEC_W      = ADDR_W - SECTOR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              sec_erase_stb,
  output logic [SEC_W-1:0]  sec_addr,
  output logic              chip_erase_stb,
  output logic              id_mode,
  output logic              id_hit,
  output logic [7:0]        id_data
);

  cyc_t cls;
  logic take;

  assign take = wr_valid && !busy;

  jfc_cycle_class u_class (
    .cmd_addr (wr_addr[CMD_AW-1:0]),
    .cmd_data (wr_data),
    .cls      (cls)
  );

  jfc_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .SECTOR_LSB (SECTOR_LSB)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .cls       (cls),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prog_stb  (prog_stb),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .sec_stb   (sec_erase_stb),
    .sec_addr  (sec_addr),
    .chip_stb  (chip_erase_stb),
    .id_mode   (id_mode)
  );

  jfc_id_read #(
    .ADDR_W (ADDR_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_id (
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .id_hit  (id_hit),
    .id_data (id_data)
  );

endmodule

// File: rtl/jfc_cmd_decoder_chk.sv
module jfc_cmd_decoder_chk #(
  parameter int ADDR_W     = 19,
  parameter int SECTOR_LSB = 12,
  localparam int SEC_W     = ADDR_W - SECTOR_LSB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              prog_stb,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        prog_data,
  input logic              sec_erase_stb,
  input logic [SEC_W-1:0]  sec_addr,
  input logic              chip_erase_stb,
  input logic              id_mode,
  input logic              id_hit
);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, sec_erase_stb, chip_erase_stb}));

  a_r11_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  a_r11_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_erase_stb || chip_erase_stb) |=> !(sec_erase_stb || chip_erase_stb));

  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !wr_valid) |=>
      (!prog_stb && !sec_erase_stb && !chip_erase_stb && $stable(id_mode)));

  a_r2_prog_fields: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  a_r3_sector_fields: assert property (@(posedge clk) disable iff (!rst_n)
    sec_erase_stb |->
      (sec_addr == $past(wr_addr[ADDR_W-1:SECTOR_LSB]) && $past(wr_data) == 8'h30));

  a_r4_chip_last: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_stb |->
      ($past(wr_data) == 8'h10 && $past(wr_addr[14:0]) == 15'h5555));

  a_r6_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |->
      ($past(wr_data) == 8'h90 && $past(wr_addr[14:0]) == 15'h5555));

  a_r7_hit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> (id_mode && rd_addr[ADDR_W-1:1] == '0));

endmodule

bind jfc_cmd_decoder jfc_cmd_decoder_chk #(
  .ADDR_W     (ADDR_W),
  .SECTOR_LSB (SECTOR_LSB)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_valid       (wr_valid),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .busy           (busy),
  .rd_addr        (rd_addr),
  .prog_stb       (prog_stb),
  .prog_addr      (prog_addr),
  .prog_data      (prog_data),
  .sec_erase_stb  (sec_erase_stb),
  .sec_addr       (sec_addr),
  .chip_erase_stb (chip_erase_stb),
  .id_mode        (id_mode),
  .id_hit         (id_hit)
);

// File: tb/sim_jfc_cmd_decoder.sv
`timescale 1ns/1ps
module sim_jfc_cmd_decoder;

  localparam int AW  = 19;
  localparam int SL  = 12;
  localparam int SW  = AW - SL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          prog_stb, sec_erase_stb, chip_erase_stb, id_mode, id_hit;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data, id_data;
  logic [SW-1:0] sec_addr;

  always #4 clk = ~clk;

  jfc_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
    .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
    .sec_erase_stb(sec_erase_stb), .sec_addr(sec_addr),
    .chip_erase_stb(chip_erase_stb), .id_mode(id_mode),
    .id_hit(id_hit), .id_data(id_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model: history of accepted writes ----------
  typedef struct {
    logic [14:0] a;
    logic [7:0]  d;
  } ent_t;
  ent_t hist[$];

  logic          m_prog = 1'b0, m_sec = 1'b0, m_chip = 1'b0, m_id = 1'b0;
  logic [AW-1:0] m_paddr = '0;
  logic [7:0]    m_pdata = '0;
  logic [SW-1:0] m_saddr = '0;

  // 0 = legal unfinished prefix, -1 = broken, 1 prog, 2 sector, 3 chip,
  // 4 id entry, 5 id exit
  function automatic int classify();
    int n = hist.size();
    if (n == 1 && hist[0].d == 8'hF0) return 5;
    if (!(hist[0].a == 15'h5555 && hist[0].d == 8'hAA)) return -1;
    if (n == 1) return 0;
    if (!(hist[1].a == 15'h2AAA && hist[1].d == 8'h55)) return -1;
    if (n == 2) return 0;
    if (hist[2].a != 15'h5555) return -1;
    if (hist[2].d == 8'h90) return 4;
    if (hist[2].d == 8'hF0) return 5;
    if (hist[2].d == 8'hA0) return (n == 3) ? 0 : 1;
    if (hist[2].d != 8'h80) return -1;
    if (n == 3) return 0;
    if (!(hist[3].a == 15'h5555 && hist[3].d == 8'hAA)) return -1;
    if (n == 4) return 0;
    if (!(hist[4].a == 15'h2AAA && hist[4].d == 8'h55)) return -1;
    if (n == 5) return 0;
    if (hist[5].d == 8'h30) return 2;
    if (hist[5].d == 8'h10 && hist[5].a == 15'h5555) return 3;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_prog <= 1'b0; m_sec <= 1'b0; m_chip <= 1'b0; m_id <= 1'b0;
    end else begin
      m_prog <= 1'b0; m_sec <= 1'b0; m_chip <= 1'b0;
      if (wr_valid && !busy) begin
        ent_t e;
        int code;
        e.a = wr_addr[14:0];
        e.d = wr_data;
        hist.push_back(e);
        code = classify();
        if (code != 0) hist.delete();
        case (code)
          -1: m_id <= 1'b0;
          1: begin m_prog <= 1'b1; m_paddr <= wr_addr; m_pdata <= wr_data; end
          2: begin m_sec <= 1'b1; m_saddr <= wr_addr[AW-1:SL]; end
          3: m_chip <= 1'b1;
          4: m_id <= 1'b1;
          5: m_id <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison -----------------------------------
  int n_prog = 0, n_sec = 0, n_chip = 0;

  always begin
    logic       exp_hit;
    logic [7:0] exp_dat;
    @(posedge clk);
    #3;
    if (!finished) begin
      chk("R2 prog_stb", prog_stb, m_prog);
      chk("R3 sec_erase_stb", sec_erase_stb, m_sec);
      chk("R4 chip_erase_stb", chip_erase_stb, m_chip);
      chk("R6 R8 id_mode", id_mode, m_id);
      if (m_prog) begin
        chk("R2 prog_addr", prog_addr, m_paddr);
        chk("R2 prog_data", prog_data, m_pdata);
      end
      if (m_sec) chk("R3 sec_addr", sec_addr, m_saddr);
      exp_hit = m_id && (rd_addr >> 1) == 0;
      exp_dat = !exp_hit ? 8'h00 : (rd_addr[0] ? 8'hB7 : 8'hBF);
      chk("R7 id_hit", id_hit, exp_hit);
      chk("R7 id_data", id_data, exp_dat);
      if (prog_stb) n_prog++;
      if (sec_erase_stb) n_sec++;
      if (chip_erase_stb) n_chip++;
    end
  end

  // ---------------- stimulus helpers ---------------------------------------
  task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic b = 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic counts(string tag, int p, int s, int c);
    @(negedge clk);
    chk({tag, " program count"}, n_prog, p);
    chk({tag, " sector count"}, n_sec, s);
    chk({tag, " chip count"}, n_chip, c);
    n_prog = 0; n_sec = 0; n_chip = 0;
  endtask

  task automatic unlock(logic [AW-1:0] hi = '0);
    wr(hi | 19'h05555, 8'hAA);
    wr(hi | 19'h02AAA, 8'h55);
  endtask

  task automatic rd_id(logic [AW-1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #3;
    chk(tag, id_data, exp);
  endtask

  // ---------------- scenario -----------------------------------------------
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {prog_stb, sec_erase_stb, chip_erase_stb}, 0);
    chk("R1 reset id_mode", id_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {prog_stb, sec_erase_stb, chip_erase_stb, id_mode}, 0);

    // R2 with R5: upper address bits set on every command step
    unlock(19'h40000);
    wr(19'h75555, 8'hA0);
    wr(19'h71234, 8'h3C);
    counts("R2 R5 program", 1, 0, 0);

    // R3 sector erase
    unlock();
    wr(19'h05555, 8'h80);
    unlock(19'h20000);
    wr(19'h63ABC, 8'h30);
    counts("R3 sector", 0, 1, 0);

    // R4 chip erase, then the misplaced final step
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h10);
    counts("R4 chip", 0, 0, 1);
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h01234, 8'h10);
    counts("R4 misplaced 10h", 0, 0, 0);

    // R6 / R7 identification reads
    unlock(); wr(19'h05555, 8'h90);
    chk("R6 id entry", id_mode, 1);
    rd_id(19'h00000, 8'hBF, "R7 manufacturer");
    rd_id(19'h00001, 8'hB7, "R7 device");
    rd_id(19'h00002, 8'h00, "R7 addr 2");
    rd_id(19'h40001, 8'h00, "R7 high bit");

    // R8 single-write exit
    wr(19'h31234, 8'hF0);
    chk("R8 single exit", id_mode, 0);
    rd_id(19'h00000, 8'h00, "R7 after exit");

    // R8 three-write exit
    unlock(); wr(19'h05555, 8'h90);
    unlock(); wr(19'h05555, 8'hF0);
    chk("R8 three-write exit", id_mode, 0);

    // R9 abort discards the breaking write and clears id mode
    unlock(); wr(19'h05555, 8'h90);
    wr(19'h05555, 8'hAA);
    wr(19'h05555, 8'hAA);
    chk("R9 abort clears id", id_mode, 0);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h00100, 8'h99);
    counts("R9 discarded start", 0, 0, 0);
    unlock(); wr(19'h05555, 8'h77);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00100, 8'h5A);
    counts("R9 recover", 1, 0, 0);

    // R10 busy writes are ignored, including F0h, without losing position
    unlock(); wr(19'h05555, 8'h90);
    wr(19'h00000, 8'hF0, 1'b1);
    chk("R10 F0 while busy", id_mode, 1);
    wr(19'h05555, 8'hAA);
    wr(19'h01111, 8'h12, 1'b1);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h0ABCD, 8'hEE, 1'b1);
    wr(19'h0ABCD, 8'hE1);
    counts("R10 busy gaps", 1, 0, 0);
    chk("R10 id kept", id_mode, 1);

    // R11 back-to-back writes with no idle cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 19'h05555; wr_data = 8'hAA; @(negedge clk);
    wr_addr = 19'h02AAA; wr_data = 8'h55; @(negedge clk);
    wr_addr = 19'h05555; wr_data = 8'hA0; @(negedge clk);
    wr_addr = 19'h00042; wr_data = 8'h24; @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    counts("R11 single pulse", 1, 0, 0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule